// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns characters written by a host into frames on an asynchronous serial line. Each frame has a start bit at space, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period at mark. The parity bit can be even, odd or a fixed level. The stop period can be set from one to two bit times in steps of one sixteenth of a bit. A single holding register sits in front of the shift engine, so the host can queue the next character while the current one is on the line.

Bit timing comes from an enable input, `tick`. In 16X mode each bit lasts sixteen ticks. In 1X mode each bit lasts one tick, and the logic that makes that enable is expected to pulse it on the falling edge of an external bit clock.

The block can also:
- hold the line at space to send a break;
- force the line to mark while an internal loopback is active;
- refuse to start a character until an active-low clear-to-send input is low;
- drive an active-low request-to-send that the host sets and clears, and that can release itself once the last queued character has left.

Top module: `uft_tx`

## Requirements
- R1: After reset, `txd` is 1, `rts_n` is 1, `tx_empty` is 1, and `tx_rdy` is 1 while `tx_en` is 1.
- R2: Frame layout:
  - A frame is one start bit at 0, then N data bits taken from `wr_data` with the least significant bit first, where N = 5 + `char_len` (codes 0 to 3 give 5 to 8 bits).
  - Data bits above N are not sent.
  - In 16X mode each bit lasts 16 `tick` pulses.
- R3: `par_mode` selects the parity bit that follows the data bits:
  - 0: no parity bit.
  - 1: even parity; the data bits and the parity bit together hold an even number of ones.
  - 2: odd parity; together they hold an odd number of ones.
  - 3: the parity bit equals `par_level`.
- R4: In 16X mode the stop period is at mark and lasts 16 + `stop_ext` ticks. Any `stop_ext` value above 16 counts as 16.
- R5: In 1X mode (`os16` = 0) every bit lasts one tick. The stop period is one tick when `stop_ext` < 16 and two ticks otherwise.
- R6: Holding register and flags:
  - A write is accepted only when `tx_rdy` is 1. A write while the holding register is full is dropped.
  - `tx_rdy` goes to 0 in the clock after an accepted write, and returns to 1 in the clock where that character starts.
  - `tx_empty` is 1 only when no character is held and none is being shifted.
  - A character already held starts in the clock after the previous stop period ends.
- R7: Clear-to-send gating:
  - While `cts_gate_en` is 1 and `cts_n` is 1, no character starts.
  - A character starts in the clock after `cts_n` goes to 0, or after gating is turned off.
  - Raising `cts_n` during a character does not disturb that character.
- R8: Break:
  - With `break_cmd` at 1, the line goes to space once the current character has fully ended, and stays there.
  - Clearing `break_cmd` gives a mark stop period of the programmed length before the transmitter is idle again.
- R9: The line is at mark whenever the transmitter is idle, and at every cycle while `loop_local` is 1. Frames still run internally and still complete during loopback.
- R10: Request-to-send:
  - A pulse on `rts_on` drives `rts_n` to 0, and a pulse on `rts_off` drives it back to 1.
  - With `rts_auto_en` at 1, `rts_n` returns to 1 in the clock where a stop period ends with nothing held.
- R11: While `tx_en` is 0, writes are dropped, `tx_rdy` is 0 and no new character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-timing enable (one sixteenth of a bit, or one bit) |
| os16 | input | 1 | 1 selects 16X timing, 0 selects 1X timing |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Write strobe for a character |
| wr_data | input | 8 | Character to send |
| char_len | input | 2 | Data bit count minus 5 |
| par_mode | input | 2 | Parity selection: none, even, odd or fixed |
| par_level | input | 1 | Parity level used in fixed mode |
| stop_ext | input | 5 | Stop period beyond one bit, in sixteenths |
| break_cmd | input | 1 | Hold the line at space after the current character |
| loop_local | input | 1 | Force the line to mark (internal loopback) |
| cts_gate_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_auto_en | input | 1 | Release request-to-send after the last character |
| rts_on | input | 1 | Pulse: assert request-to-send |
| rts_off | input | 1 | Pulse: deassert request-to-send |
| txd | output | 1 | Serial line, 1 = mark |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Nothing held and nothing being shifted |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
With `tick` held high, a write sampled at clock edge A makes `tx_rdy` and `tx_empty` fall at that same edge. The start bit begins at the next edge B. Bit k of the frame then occupies the clocks from B + 16k up to B + 16k + 15 in 16X mode, or the single clock B + k in 1X mode. The idle state, together with any request-to-send release, follows exactly at the clock where the stop period ends.

The bench samples at falling edges and counts each expected position from edge B. It compares `txd` at every clock of the frame against a waveform it builds by arithmetic from the data, length, parity and stop settings. It then checks the flags at the first clock after the frame.

Break entry and exit, clear-to-send release and gating release are each checked at the single clock where the start or the stop period is due.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4,
      ST_BRK   = 3'd5
   } tx_state_t;

   typedef enum logic [1:0] {
      PAR_NONE  = 2'd0,
      PAR_EVEN  = 2'd1,
      PAR_ODD   = 2'd2,
      PAR_FORCE = 2'd3
   } par_mode_t;

endpackage

// File: rtl/uft_hold.sv
// One-character holding stage in front of the shift engine.
module uft_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else if (load) begin
         full <= 1'b1;
         dout <= din;
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/uft_bit_timer.sv
// Counts ticks inside one frame segment and flags the segment's last tick.
module uft_bit_timer #(
   parameter int OVS    = 16,
   parameter int STOP_W = 5,
   localparam int CNT_W = $clog2(2 * OVS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              os16,
   input  logic              in_stop,
   input  logic              clr,
   input  logic [STOP_W-1:0] stop_ext,
   output logic              done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] ext_sat;

   always_comb begin
      ext_sat = (stop_ext > STOP_W'(OVS)) ? CNT_W'(OVS) : CNT_W'(stop_ext);
      if (os16) begin
         lim = in_stop ? (CNT_W'(OVS - 1) + ext_sat) : CNT_W'(OVS - 1);
      end else begin
         lim = (in_stop && (stop_ext >= STOP_W'(OVS))) ? CNT_W'(1) : '0;
      end
      done = tick && (cnt_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/uft_ser_fsm.sv
// Frame sequencer: start, data, parity, stop and break segments.
module uft_ser_fsm
   import uft_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2,
   parameter int BIT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              can_start,
   input  logic              brk_req,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [LEN_W-1:0]  char_len,
   input  logic [1:0]        par_mode,
   input  logic              par_level,
   input  logic              bit_done,
   output tx_state_t         state_q,
   output logic              take,
   output logic              seg_chg,
   output logic              stop_end,
   output logic              line_bit
);

   tx_state_t         state_d;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] masked;
   logic [BIT_W-1:0]  bitcnt;
   logic [BIT_W-1:0]  nbits;
   logic              par_q;
   logic              par_nx;
   logic              par_en;

   always_comb begin
      nbits = BIT_W'(MIN_BITS) + BIT_W'(char_len);
      for (int i = 0; i < DATA_W; i++) begin
         mask[i] = (i < int'(nbits));
      end
      masked = hold_data & mask;
      par_en = (par_mode_t'(par_mode) != PAR_NONE);
      case (par_mode_t'(par_mode))
         PAR_EVEN:  par_nx = ^masked;
         PAR_ODD:   par_nx = ~^masked;
         PAR_FORCE: par_nx = par_level;
         default:   par_nx = 1'b0;
      endcase
   end

   always_comb begin
      state_d  = state_q;
      take     = 1'b0;
      stop_end = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (brk_req) begin
               state_d = ST_BRK;
            end else if (can_start) begin
               state_d = ST_START;
               take    = 1'b1;
            end
         end
         ST_START: if (bit_done) state_d = ST_DATA;
         ST_DATA: begin
            if (bit_done && (bitcnt == nbits - BIT_W'(1))) begin
               state_d = par_en ? ST_PAR : ST_STOP;
            end
         end
         ST_PAR: if (bit_done) state_d = ST_STOP;
         ST_STOP: begin
            if (bit_done) begin
               state_d  = ST_IDLE;
               stop_end = 1'b1;
            end
         end
         ST_BRK: if (!brk_req) state_d = ST_STOP;
         default: state_d = ST_IDLE;
      endcase
      seg_chg = (state_d != state_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg   <= '0;
         par_q   <= 1'b0;
         bitcnt  <= '0;
      end else begin
         state_q <= state_d;
         if (take) begin
            shreg  <= masked;
            par_q  <= par_nx;
            bitcnt <= '0;
         end else if ((state_q == ST_DATA) && bit_done) begin
            shreg  <= shreg >> 1;
            bitcnt <= bitcnt + BIT_W'(1);
         end
      end
   end

   always_comb begin
      case (state_q)
         ST_START: line_bit = 1'b0;
         ST_DATA:  line_bit = shreg[0];
         ST_PAR:   line_bit = par_q;
         ST_BRK:   line_bit = 1'b0;
         default:  line_bit = 1'b1;
      endcase
   end

endmodule

// File: rtl/uft_tx.sv
module uft_tx
   import uft_pkg::*;
#(
   parameter int  DATA_W   = 8,
   parameter int  MIN_BITS = 5,
   parameter int  OVS      = 16,
   parameter bit  CTS_GATE = 1'b1,
   localparam int LEN_W    = $clog2(DATA_W - MIN_BITS + 1),
   localparam int STOP_W   = $clog2(OVS + 1),
   localparam int BIT_W    = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              os16,
   input  logic              tx_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LEN_W-1:0]  char_len,
   input  logic [1:0]        par_mode,
   input  logic              par_level,
   input  logic [STOP_W-1:0] stop_ext,
   input  logic              break_cmd,
   input  logic              loop_local,
   input  logic              cts_gate_en,
   input  logic              cts_n,
   input  logic              rts_auto_en,
   input  logic              rts_on,
   input  logic              rts_off,
   output logic              txd,
   output logic              tx_rdy,
   output logic              tx_empty,
   output logic              rts_n
);

   localparam int SPAN = DATA_W - MIN_BITS + 1;

   if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("uft_tx: OVS must be a power of two of at least 2");
   end
   if (MIN_BITS < 1 || DATA_W <= MIN_BITS || (SPAN & (SPAN - 1)) != 0) begin : g_bad_len
      $error("uft_tx: DATA_W - MIN_BITS + 1 must be a power of two of at least 2");
   end

   tx_state_t         fsm_state;
   logic [DATA_W-1:0] hold_data;
   logic              hold_full;
   logic              load;
   logic              take;
   logic              seg_chg;
   logic              stop_end;
   logic              line_bit;
   logic              bit_done;
   logic              cts_ok;
   logic              can_start;
   logic              rts_act;

   if (CTS_GATE) begin : g_cts
      assign cts_ok = !cts_gate_en || !cts_n;
   end else begin : g_nocts
      assign cts_ok = 1'b1;
   end

   assign load      = wr_stb && tx_en && !hold_full;
   assign can_start = hold_full && tx_en && cts_ok;

   uft_hold #(.DATA_W(DATA_W)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .take (take),
      .din  (wr_data),
      .dout (hold_data),
      .full (hold_full)
   );

   uft_bit_timer #(.OVS(OVS), .STOP_W(STOP_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .os16    (os16),
      .in_stop (fsm_state == ST_STOP),
      .clr     (seg_chg),
      .stop_ext(stop_ext),
      .done    (bit_done)
   );

   uft_ser_fsm #(
      .DATA_W  (DATA_W),
      .MIN_BITS(MIN_BITS),
      .LEN_W   (LEN_W),
      .BIT_W   (BIT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .can_start(can_start),
      .brk_req  (break_cmd),
      .hold_data(hold_data),
      .char_len (char_len),
      .par_mode (par_mode),
      .par_level(par_level),
      .bit_done (bit_done),
      .state_q  (fsm_state),
      .take     (take),
      .seg_chg  (seg_chg),
      .stop_end (stop_end),
      .line_bit (line_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   rts_act <= 1'b0;
      else if (rts_on)                              rts_act <= 1'b1;
      else if (rts_off)                             rts_act <= 1'b0;
      else if (rts_auto_en && stop_end && !hold_full) rts_act <= 1'b0;
   end

   assign txd      = loop_local | line_bit;
   assign tx_rdy   = tx_en && !hold_full;
   assign tx_empty = !hold_full && (fsm_state == ST_IDLE);
   assign rts_n    = !rts_act;

endmodule

// File: rtl/uft_tx_chk.sv
module uft_tx_chk
   import uft_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      txd,
   input logic      tx_rdy,
   input logic      tx_empty,
   input logic      tx_en,
   input logic      wr_stb,
   input logic      cts_gate_en,
   input logic      cts_n,
   input logic      break_cmd,
   input logic      rts_n,
   input logic      rts_off,
   input logic      rts_auto_en,
   input tx_state_t st
);

   assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> txd);

   assert_stop_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> txd);

   assert_cts_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cts_gate_en && cts_n) |=> (st != ST_START));

   assert_break_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRK && !break_cmd) |=> (st == ST_STOP));

   assert_rdy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_rdy) |-> ($past(wr_stb) || !tx_en));

   assert_rts_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rts_n) |-> ($past(rts_off) || $past(rts_auto_en)));

   assert_disabled_nostart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !tx_en) |=> (st != ST_START));

endmodule

bind uft_tx uft_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .txd        (txd),
   .tx_rdy     (tx_rdy),
   .tx_empty   (tx_empty),
   .tx_en      (tx_en),
   .wr_stb     (wr_stb),
   .cts_gate_en(cts_gate_en),
   .cts_n      (cts_n),
   .break_cmd  (break_cmd),
   .rts_n      (rts_n),
   .rts_off    (rts_off),
   .rts_auto_en(rts_auto_en),
   .st         (fsm_state)
);

// File: tb/tb_uft_tx.sv
`timescale 1ns/1ps
module tb_uft_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       os16 = 1'b1;
   logic       tx_en = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] char_len = 2'd3;
   logic [1:0] par_mode = 2'd0;
   logic       par_level = 1'b0;
   logic [4:0] stop_ext = 5'd0;
   logic       break_cmd = 1'b0;
   logic       loop_local = 1'b0;
   logic       cts_gate_en = 1'b0;
   logic       cts_n = 1'b0;
   logic       rts_auto_en = 1'b0;
   logic       rts_on = 1'b0;
   logic       rts_off = 1'b0;
   logic       txd, tx_rdy, tx_empty, rts_n;

   int checks = 0;
   int errors = 0;
   int bad;
   logic [7:0] dd;
   int ext16 [4] = '{0, 5, 16, 20};
   int ext1  [3] = '{0, 15, 16};

   always #2 clk = ~clk;

   uft_tx dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .os16(os16), .tx_en(tx_en),
      .wr_stb(wr_stb), .wr_data(wr_data), .char_len(char_len),
      .par_mode(par_mode), .par_level(par_level), .stop_ext(stop_ext),
      .break_cmd(break_cmd), .loop_local(loop_local),
      .cts_gate_en(cts_gate_en), .cts_n(cts_n), .rts_auto_en(rts_auto_en),
      .rts_on(rts_on), .rts_off(rts_off),
      .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rts_n(rts_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic exp_line(int j, logic [7:0] d, int n, int ub, int body);
      int k;
      int ones;
      if (loop_local) return 1'b1;
      if (j >= body) return 1'b1;
      k = j / ub;
      if (k == 0) return 1'b0;
      if (k <= n) return d[k-1];
      ones = 0;
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      case (par_mode)
         2'd1:    return ((ones % 2) == 1) ? 1'b1 : 1'b0;
         2'd2:    return ((ones % 2) == 1) ? 1'b0 : 1'b1;
         default: return par_level;
      endcase
   endfunction

   // Called at the falling edge just after the start bit began (j = 0).
   task automatic frame_j0(input logic [7:0] d, input bit want_empty, input string tag);
      int n, pb, ub, stopd, body, len, mism;
      n     = 5 + int'(char_len);
      pb    = (par_mode != 2'd0) ? 1 : 0;
      ub    = os16 ? 16 : 1;
      stopd = os16 ? 16 + ((stop_ext > 5'd16) ? 16 : int'(stop_ext))
                   : ((stop_ext >= 5'd16) ? 2 : 1);
      body  = ub * (1 + n + pb);
      len   = body + stopd;
      mism  = 0;
      for (int j = 0; j < len; j++) begin
         if (txd !== exp_line(j, d, n, ub, body)) mism++;
         @(negedge clk);
      end
      chk(mism == 0, tag, "frame positions differing", mism, 0);
      chk(txd === 1'b1 && tx_empty === want_empty, "R6",
          "idle after stop {txd,tx_empty}", int'({txd, tx_empty}), int'({1'b1, want_empty}));
   endtask

   task automatic write_char(input logic [7:0] d);
      wr_data = d;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input string tag);
      write_char(d);
      chk(tx_rdy === 1'b0 && tx_empty === 1'b0, "R6", "flags after write {rdy,empty}",
          int'({tx_rdy, tx_empty}), 0);
      @(negedge clk);
      frame_j0(d, 1'b1, tag);
   endtask

   task automatic pulse_rts(input bit on);
      if (on) rts_on = 1'b1; else rts_off = 1'b1;
      @(negedge clk);
      rts_on  = 1'b0;
      rts_off = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1 && rts_n === 1'b1,
          "R1", "reset {txd,rdy,empty,rts_n}", int'({txd, tx_rdy, tx_empty, rts_n}), 15);

      // R2 R3 R4 sweep in 16X mode
      os16 = 1'b1;
      for (int cl = 0; cl < 4; cl++) begin
         for (int pm = 0; pm < 4; pm++) begin
            for (int e = 0; e < 4; e++) begin
               char_len  = 2'(cl);
               par_mode  = 2'(pm);
               par_level = 1'((cl + pm + e) % 2);
               stop_ext  = 5'(ext16[e]);
               dd = 8'(8'h5A + cl * 53 + pm * 29 + e * 7);
               send(dd, "R2 R3 R4");
            end
         end
      end

      // R5 sweep in 1X mode
      os16 = 1'b0;
      for (int cl = 0; cl < 4; cl++) begin
         for (int pm = 0; pm < 4; pm++) begin
            for (int e = 0; e < 3; e++) begin
               char_len  = 2'(cl);
               par_mode  = 2'(pm);
               par_level = 1'((cl + e) % 2);
               stop_ext  = 5'(ext1[e]);
               dd = 8'(8'hC3 + cl * 41 + pm * 17 + e * 5);
               send(dd, "R5");
            end
         end
      end

      os16 = 1'b1; char_len = 2'd3; par_mode = 2'd0; stop_ext = 5'd3;

      // R6 write while full is dropped
      wr_data = 8'h3C; wr_stb = 1'b1;
      @(negedge clk);
      wr_data = 8'hE1;
      @(negedge clk);
      wr_stb = 1'b0;
      chk(tx_rdy === 1'b1, "R6", "holding free once started", int'(tx_rdy), 1);
      frame_j0(8'h3C, 1'b1, "R6 second write dropped");

      // R6 back-to-back characters
      write_char(8'h96);
      @(negedge clk);
      fork
         frame_j0(8'h96, 1'b0, "R6 first of pair");
         begin
            wr_data = 8'h0F; wr_stb = 1'b1;
            @(negedge clk);
            wr_stb = 1'b0;
         end
      join
      @(negedge clk);
      frame_j0(8'h0F, 1'b1, "R6 second of pair");

      // R7 clear-to-send gating
      cts_gate_en = 1'b1; cts_n = 1'b1;
      write_char(8'hA7);
      bad = 0;
      repeat (40) begin
         @(negedge clk);
         if (txd !== 1'b1 || tx_empty !== 1'b0 || tx_rdy !== 1'b0) bad++;
      end
      chk(bad == 0, "R7", "cycles started while clear-to-send high", bad, 0);
      cts_n = 1'b0;
      @(negedge clk);
      frame_j0(8'hA7, 1'b1, "R7 start after clear-to-send low");
      write_char(8'h58);
      @(negedge clk);
      fork
         frame_j0(8'h58, 1'b1, "R7 character in progress completes");
         begin
            repeat (20) @(negedge clk);
            cts_n = 1'b1;
         end
      join
      write_char(8'h21);
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (tx_empty !== 1'b0 || txd !== 1'b1) bad++;
      end
      chk(bad == 0, "R7", "held character started while gated", bad, 0);
      cts_gate_en = 1'b0;
      @(negedge clk);
      frame_j0(8'h21, 1'b1, "R7 gating turned off");
      cts_n = 1'b0;

      // R8 break from idle
      break_cmd = 1'b1;
      @(negedge clk);
      chk(txd === 1'b0 && tx_empty === 1'b0, "R8", "break entry {txd,empty}",
          int'({txd, tx_empty}), 0);
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (txd !== 1'b0) bad++;
      end
      chk(bad == 0, "R8", "break space held", bad, 0);
      break_cmd = 1'b0;
      @(negedge clk);
      bad = 0;
      for (int k = 0; k < 19; k++) begin
         if (txd !== 1'b1) bad++;
         if (k == 0 && tx_empty !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0 && tx_empty === 1'b1, "R8", "mark period after break then idle",
          bad, 0);

      // R8 break raised during a character
      write_char(8'h6D);
      @(negedge clk);
      fork
         frame_j0(8'h6D, 1'b1, "R8 character completes before break");
         begin
            repeat (5) @(negedge clk);
            break_cmd = 1'b1;
         end
      join
      @(negedge clk);
      chk(txd === 1'b0, "R8", "space after character end", int'(txd), 0);
      break_cmd = 1'b0;
      repeat (20) @(negedge clk);
      chk(tx_empty === 1'b1 && txd === 1'b1, "R8", "idle after break stop {txd,empty}",
          int'({txd, tx_empty}), 3);

      // R9 loopback holds mark
      loop_local = 1'b1;
      send(8'h00, "R9 loopback mark");
      loop_local = 1'b0;

      // R10 request-to-send
      rts_auto_en = 1'b1;
      pulse_rts(1'b1);
      chk(rts_n === 1'b0, "R10", "rts asserted", int'(rts_n), 0);
      send(8'h99, "R10 frame");
      chk(rts_n === 1'b1, "R10", "auto release after last character", int'(rts_n), 1);
      rts_auto_en = 1'b0;
      pulse_rts(1'b1);
      send(8'h42, "R10 frame without auto release");
      chk(rts_n === 1'b0, "R10", "rts kept without auto release", int'(rts_n), 0);
      pulse_rts(1'b0);
      chk(rts_n === 1'b1, "R10", "rts cleared by host", int'(rts_n), 1);

      // R11 transmitter disabled
      tx_en = 1'b0;
      @(negedge clk);
      chk(tx_rdy === 1'b0, "R11", "ready while disabled", int'(tx_rdy), 0);
      write_char(8'h11);
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (txd !== 1'b1 || tx_empty !== 1'b1) bad++;
      end
      chk(bad == 0, "R11", "activity while disabled", bad, 0);
      tx_en = 1'b1;
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (tx_empty !== 1'b1 || tx_rdy !== 1'b1) bad++;
      end
      chk(bad == 0, "R11", "write while disabled was kept", bad, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule